// File: doc/BRIEF.md
# Re-encoded Scan Shift Register

This block is a short scan shift register whose flip-flops keep their contents in one of two encodings, chosen by a mode input. In test mode every flip-flop holds its logical bit as it is, so a tester driving the serial input and watching the serial output sees an ordinary shift register. In system mode a chosen subset of the stages holds the inverse of its logical bit. Inverters on the stage-to-stage paths and on the capture path make up for the inversion, so the serial sequence and the captured data are unchanged.

Each stage has a multiplexer. With shift enabled, the stage takes the logical bit of the stage before it. With shift disabled, it takes a bit of the parallel capture word from the surrounding logic. The encoding that applies to the stored bits is tracked in a register. When the mode input changes, the very next clock edge writes the new state in the new encoding, so the logical contents are not lost across the switch. A decoded parallel readout gives the logical state to the surrounding logic in both modes.

Top module: `rescan_reg`

## Requirements
- R1: A clock edge with `rst_n` low clears the logical state, so `state_out` reads 0 and `scan_out` reads 0, whatever mode was in use before.
- R2: With `sys_mode` = 0 and `scan_en` = 1, a bit driven on `scan_in` appears on `scan_out` after exactly STAGES clock edges.
- R3: With `sys_mode` = 1 and `scan_en` = 1, the serial behaviour is the same as in R2: `scan_out` after an edge equals `state_out[STAGES-2]` before that edge.
- R4: In system mode, every stage whose bit in ENC_MASK is 1 (by default bits 0 and 1) stores the inverse of its logical bit. The last stage is always stored true and drives `scan_out` directly.
- R5: With `scan_en` = 0, one clock edge loads `cap_data` into the logical state: `state_out` equals the `cap_data` from before the edge, in either mode.
- R6: Shift order: with `scan_en` = 1, after an edge `state_out` = {previous `state_out`[STAGES-2:0], `scan_in`}. Bit 0 is the stage nearest the input, and bit STAGES-1 is the stage that drives `scan_out`.
- R7: A change of `sys_mode` between two edges leaves the logical state intact. The edge after the change obeys R5 or R6 exactly as if the mode had not changed.
- R8: `scan_out` always equals `state_out[STAGES-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_mode | input | 1 | 0 = test encoding (plain), 1 = system encoding (masked) |
| scan_en | input | 1 | 1 = shift from previous stage, 0 = capture from cap_data |
| scan_in | input | 1 | Serial input to the first stage |
| cap_data | input | STAGES | Parallel functional capture word, bit 0 to the first stage |
| scan_out | output | 1 | Serial output from the last stage |
| state_out | output | STAGES | Decoded logical state |

## Verification
The bench builds the block with its defaults: three stages and mask 3'b011. With these values both inverted stages and the single true stage are exercised, and a bit passes through every kind of inter-stage path (true to inverted, inverted to inverted, inverted to true) within three edges. A stimulus table with hand-placed mode toggles in the middle of shifts and captures is followed by a few hundred random cycles. Both are compared against a plain three-bit shift register model. This covers re-encoding on every mix of mode change and shift or capture, including reset taken while in system mode.

// File: rtl/rescan_pkg.sv
// Shared definitions for the re-encoded scan register.
// Assumes: a mode value of 1 selects the masked (system) encoding.
package rescan_pkg;
    typedef enum logic {
        ENC_PLAIN  = 1'b0,
        ENC_MASKED = 1'b1
    } enc_mode_e;
endpackage

// File: rtl/rescan_mode_reg.sv
// Holds the encoding that applies to the bits currently stored in the stages.
// Assumes: the stages write their next value in the encoding named by the
// mode input, so this register always lags that input by exactly one edge.
module rescan_mode_reg
    import rescan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_nxt,
    output enc_mode_e mode_cur
);
    // Track the encoding of the word written on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_cur <= ENC_PLAIN;
        else        mode_cur <= enc_mode_e'(mode_nxt);
    end
endmodule

// File: rtl/rescan_stage.sv
// One stage of the scan register: capture/shift mux followed by an optional
// inverter that applies the system-mode encoding before the flip-flop.
// Assumes: shift_d and cap_d are logical (decoded) values.
module rescan_stage #(
    parameter bit INV = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic shift_d,
    input  logic cap_d,
    input  logic mode_cur,
    input  logic mode_nxt,
    output logic q
);
    logic d_logic;
    logic d_enc;

    // Pick shift data or capture data, both in logical form.
    always_comb d_logic = scan_en ? shift_d : cap_d;

    // Encode for the mode in force after this edge.
    always_comb d_enc = d_logic ^ (INV & mode_nxt);

    // Store the encoded bit; reset gives a logical zero in plain encoding.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d_enc;
    end

    generate
        if (INV) begin : g_inv_chk
            // R4
            masked_store_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(scan_en) && mode_cur) |-> (q == !$past(shift_d)));
        end else begin : g_true_chk
            // R4
            true_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(scan_en)) |-> (q == $past(shift_d)));
        end
    endgenerate

    // R5
    plain_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(scan_en) && !mode_cur) |-> (q == $past(cap_d)));
endmodule

// File: rtl/rescan_reg.sv
// Scan shift register with mode-dependent state encoding. In plain mode the
// stages hold logical bits; in masked mode stages flagged in ENC_MASK hold
// inverted bits. Serial and capture behaviour are identical in both modes.
// Assumes: ENC_MASK[STAGES-1] is 0 so the last stage drives scan_out unaltered.
module rescan_reg #(
    parameter int                STAGES   = 3,
    parameter logic [STAGES-1:0] ENC_MASK = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_mode,
    input  logic              scan_en,
    input  logic              scan_in,
    input  logic [STAGES-1:0] cap_data,
    output logic              scan_out,
    output logic [STAGES-1:0] state_out
);
    import rescan_pkg::*;

    localparam int LAST = STAGES - 1;

    enc_mode_e         mode_cur;
    logic [STAGES-1:0] raw;
    logic [STAGES-1:0] logical;
    logic [STAGES-1:0] shift_src;

    rescan_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_nxt(sys_mode),
        .mode_cur(mode_cur)
    );

    // Undo the stored encoding to obtain the logical state.
    always_comb logical = raw ^ ((mode_cur == ENC_MASKED) ? ENC_MASK : '0);

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                // First stage shifts from the serial input.
                assign shift_src[i] = scan_in;
            end else begin : g_body
                // Later stages shift from the decoded previous stage.
                assign shift_src[i] = logical[i-1];
            end
            rescan_stage #(.INV(ENC_MASK[i])) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .scan_en (scan_en),
                .shift_d (shift_src[i]),
                .cap_d   (cap_data[i]),
                .mode_cur(mode_cur),
                .mode_nxt(sys_mode),
                .q       (raw[i])
            );
        end
    endgenerate

    // Serial output straight from the last stage (stored true).
    always_comb scan_out = raw[LAST];
    // Parallel readout in logical form.
    always_comb state_out = logical;

    // R6
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(scan_en)) |->
        (state_out == {$past(state_out[STAGES-2:0]), $past(scan_in)}));
    // R5
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(scan_en)) |-> (state_out == $past(cap_data)));
    // R3
    serial_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(scan_en)) |-> (scan_out == $past(state_out[STAGES-2])));
    // R8
    out_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out == state_out[LAST]);
endmodule

// File: tb/rescan_reg_test.sv
module rescan_reg_test;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sys_mode = 1'b0;
    logic         scan_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] cap_data = '0;
    logic         scan_out;
    logic [N-1:0] state_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [N-1:0] ref_q = '0;
    logic         prev_mode = 1'b0;

    rescan_reg uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_mode (sys_mode),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .cap_data (cap_data),
        .scan_out (scan_out),
        .state_out(state_out)
    );

    always #5 clk = ~clk;

    // Stimulus vectors {sys_mode, scan_en, scan_in, cap_data[2:0]}
    localparam logic [5:0] VEC [16] = '{
        6'b010_000, 6'b011_000, 6'b010_000, 6'b011_000,
        6'b111_000, 6'b111_000, 6'b110_000, 6'b010_000,
        6'b100_101, 6'b111_000, 6'b000_110, 6'b110_000,
        6'b101_011, 6'b011_000, 6'b100_111, 6'b010_000
    };

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Apply one cycle (called at a falling edge), update model, check.
    task automatic step(input logic y, input logic se, input logic si, input logic [N-1:0] cd);
        string tag;
        sys_mode = y; scan_en = se; scan_in = si; cap_data = cd;
        @(posedge clk);
        if (se) ref_q = {ref_q[N-2:0], si};
        else    ref_q = cd;
        #2;
        if (se) tag = (y != prev_mode) ? "R7 shift across mode change" : "R6 shift order";
        else    tag = (y != prev_mode) ? "R7 capture across mode change" : "R5 capture";
        chk(tag, state_out, ref_q);
        chk(y ? "R3 serial out system mode" : "R2 serial out test mode",
            {2'b00, scan_out}, {2'b00, ref_q[N-1]});
        chk("R8 scan_out vs state_out", {2'b00, scan_out}, {2'b00, state_out[N-1]});
        prev_mode = y;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #1000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] keep;
        // R1 reset state
        repeat (2) @(negedge clk);
        chk("R1 reset state_out", state_out, '0);
        chk("R1 reset scan_out", {2'b00, scan_out}, 3'b000);
        rst_n = 1'b1;

        // Table walk
        foreach (VEC[k]) step(VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][2:0]);

        // R2 latency: lone 1 in test mode emerges after exactly N edges
        step(0, 0, 0, 3'b000);
        step(0, 1, 1, 3'b000);
        step(0, 1, 0, 3'b000);
        chk("R2 not yet out", {2'b00, scan_out}, 3'b000);
        step(0, 1, 0, 3'b000);
        chk("R2 out after N edges", {2'b00, scan_out}, 3'b001);

        // R4/R7: load in test mode, switch to system mode with capture of same word
        step(0, 0, 0, 3'b101);
        keep = state_out;
        step(1, 0, 0, keep);
        chk("R7 logical kept after switch", state_out, 3'b101);
        step(0, 0, 0, state_out);
        chk("R7 logical kept after switch back", state_out, 3'b101);

        // Random phase
        for (int r = 0; r < 400; r++)
            step(1'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom), 3'($urandom));

        // R1 reset taken while in system mode with nonzero state
        step(1, 0, 0, 3'b111);
        rst_n = 1'b0; sys_mode = 1'b1;
        @(posedge clk); #2;
        chk("R1 reset from system mode", state_out, '0);
        chk("R1 reset scan_out from system mode", {2'b00, scan_out}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1; ref_q = '0; prev_mode = 1'b0;
        step(1, 1, 1, 3'b000);
        step(1, 1, 0, 3'b000);
        step(1, 1, 0, 3'b000);
        chk("R3 out after N edges in system mode", {2'b00, scan_out}, 3'b001);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule